// File: doc/BRIEF.md
# Ping-pong audio DMA channel

This block is a single-direction DMA channel that streams 16-bit audio words from memory into a peripheral FIFO. It holds two buffer descriptors, each a start address and a transfer count, and runs them alternately. While one buffer is being played out, software refills and re-arms the other. Playback can then continue without a gap in the sample stream.

Each slot has an enable flag and a done flag. When a slot's count is used up, its done flag rises and its enable drops. The active-buffer indicator then flips to the other slot, and the channel continues there if that slot is armed. If the other slot is not armed, the channel idles until it is. The interrupt line combines the done flags through per-slot interrupt enables. If both done flags are seen set together, a refill was missed, and software stops and restarts the channel. If an interrupt arrives with neither done flag set, software treats it as spurious.

Memory is reached through a request/acknowledge read port. The FIFO side is a valid/ready push port.

Top module: `ppdma_channel`

## Requirements
- R1: After reset, mem_req, per_valid, busy and irq are 0, both done flags are 0, active is 0 and residue is 0.
- R2: A descriptor write (desc_wr, with desc_sel picking slot 0 or 1) stores a byte start address and a count in 16-bit units. A running slot reads one word per transfer at mem_addr, starting at the start address and stepping by 2 bytes. Each word goes out on per_data in the order it was read.
- R3: mem_req stays high, with mem_addr held, until mem_ack. per_valid stays high, with per_data held, until per_ready. The two are never high in the same cycle.
- R4: When the last word of a slot is accepted by the FIFO, that slot's done flag sets, its enable clears, and active flips to the other slot (0 to 1 or 1 to 0).
- R5: After a slot finishes, the channel starts the other slot by itself if that slot is enabled and the channel is running. Otherwise it goes idle with no memory request until the slot is enabled with en_set.
- R6: A done flag stays set until its done_clr bit is pulsed.
- R7: irq is high exactly when some slot has both its done flag and its irq_en bit set.
- R8: residue loads the slot count when a slot starts. It drops by one each time a word is accepted by the FIFO, and reaches 0 at the end of the slot.
- R9: After stop, no new memory request is issued. A request already outstanding still completes, and its word is still pushed. A later start reloads the active slot's descriptor from its start address.
- R10: An enabled slot with count 0 completes at once: its done flag sets and active flips, with no memory request and no FIFO push.
- R11: Rewriting the descriptor of a slot that is running does not change the transfers already under way. The new values take effect the next time that slot is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| desc_wr | input | 1 | Descriptor write strobe |
| desc_sel | input | 1 | Slot chosen by the descriptor write |
| desc_addr | input | AW | Buffer start byte address |
| desc_cnt | input | CW | Buffer length in 16-bit words |
| en_set | input | 2 | Arm slot 1 / slot 0 (one-cycle pulse per bit) |
| done_clr | input | 2 | Clear done flag of slot 1 / slot 0 |
| irq_en | input | 2 | Interrupt enable per slot |
| start | input | 1 | Set the channel running |
| stop | input | 1 | Stop at the next transfer boundary (wins over start) |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW | Memory read byte address |
| mem_ack | input | 1 | Memory read accepted, data valid |
| mem_rdata | input | 16 | Memory read data |
| per_valid | output | 1 | Word offered to the FIFO |
| per_data | output | 16 | Word to the FIFO |
| per_ready | input | 1 | FIFO accepts the word |
| done | output | 2 | Done flags of slot 1 / slot 0 |
| active | output | 1 | Slot currently in use |
| residue | output | CW | Words left in the active slot |
| busy | output | 1 | A transfer is in progress |
| irq | output | 1 | Interrupt request |

## Verification
A table of slot pairs is run back to back, in some cases with both ports flowing freely and in others with the memory acknowledge and FIFO ready alternating every cycle. These runs separate errors in address stepping and word order from errors in handshake holding and slot chaining. They use single-word slots, slots that share an address, and slots of unequal length. Directed cases then cover the following:
- a single armed slot: the channel must wait rather than reuse a stale descriptor, then resume when the other slot is armed late;
- a zero-length slot;
- the irq masking combinations;
- a stop issued while a read is held unacknowledged, together with a descriptor rewrite: the in-flight word must finish with its old address, and the restart must pick up the new descriptor.

// File: rtl/ppdma_pkg.sv
package ppdma_pkg;
    localparam int unsigned PPDMA_DW    = 16;
    localparam int unsigned PPDMA_NSLOT = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_PUSH  = 2'd2
    } ppdma_state_e;
endpackage

// File: rtl/ppdma_slot.sv
module ppdma_slot #(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [CW-1:0] wr_cnt,
    input  logic          arm,
    input  logic          clr_done,
    input  logic          finish,
    output logic [AW-1:0] addr,
    output logic [CW-1:0] cnt,
    output logic          en,
    output logic          done
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic [CW-1:0] cnt;
        logic          en;
        logic          done;
    } slot_t;

    slot_t q, d;

    always_comb begin
        d = q;
        if (wr_en) begin
            d.addr = wr_addr;
            d.cnt  = wr_cnt;
        end
        // completion disarms; a fresh arm in the same cycle wins
        if (finish)   d.en = 1'b0;
        if (arm)      d.en = 1'b1;
        // a completion event is never lost to a simultaneous clear
        if (clr_done) d.done = 1'b0;
        if (finish)   d.done = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign addr = q.addr;
    assign cnt  = q.cnt;
    assign en   = q.en;
    assign done = q.done;
endmodule

// File: rtl/ppdma_engine.sv
module ppdma_engine
    import ppdma_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 14
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            start,
    input  logic                            stop,
    input  logic [PPDMA_NSLOT-1:0][AW-1:0]  slot_addr,
    input  logic [PPDMA_NSLOT-1:0][CW-1:0]  slot_cnt,
    input  logic [PPDMA_NSLOT-1:0]          slot_en,
    output logic [PPDMA_NSLOT-1:0]          finish,
    output logic                            mem_req,
    output logic [AW-1:0]                   mem_addr,
    input  logic                            mem_ack,
    input  logic [PPDMA_DW-1:0]             mem_rdata,
    output logic                            per_valid,
    output logic [PPDMA_DW-1:0]             per_data,
    input  logic                            per_ready,
    output logic                            active,
    output logic [CW-1:0]                   residue,
    output logic                            busy
);
    localparam int unsigned STEP = PPDMA_DW / 8;

    typedef struct packed {
        ppdma_state_e         st;
        logic                 run;
        logic                 act;
        logic [AW-1:0]        ptr;
        logic [CW-1:0]        res;
        logic [PPDMA_DW-1:0]  word;
    } eng_t;

    eng_t q, d;
    logic run_now;

    always_comb begin
        d       = q;
        finish  = '0;
        run_now = (q.run | start) & ~stop;
        d.run   = run_now;

        unique case (q.st)
            ST_IDLE: begin
                if (run_now && slot_en[q.act]) begin
                    if (slot_cnt[q.act] == '0) begin
                        finish[q.act] = 1'b1;
                        d.act         = ~q.act;
                    end else begin
                        d.ptr = slot_addr[q.act];
                        d.res = slot_cnt[q.act];
                        d.st  = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                if (mem_ack) begin
                    d.word = mem_rdata;
                    d.st   = ST_PUSH;
                end
            end
            ST_PUSH: begin
                if (per_ready) begin
                    d.res = q.res - CW'(1);
                    d.ptr = q.ptr + AW'(STEP);
                    if (q.res == CW'(1)) begin
                        finish[q.act] = 1'b1;
                        d.act         = ~q.act;
                        d.st          = ST_IDLE;
                    end else begin
                        d.st = run_now ? ST_FETCH : ST_IDLE;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign mem_req   = (q.st == ST_FETCH);
    assign mem_addr  = q.ptr;
    assign per_valid = (q.st == ST_PUSH);
    assign per_data  = q.word;
    assign active    = q.act;
    assign residue   = q.res;
    assign busy      = (q.st != ST_IDLE);
endmodule

// File: rtl/ppdma_channel.sv
module ppdma_channel
    import ppdma_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 14
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   desc_wr,
    input  logic                   desc_sel,
    input  logic [AW-1:0]          desc_addr,
    input  logic [CW-1:0]          desc_cnt,
    input  logic [1:0]             en_set,
    input  logic [1:0]             done_clr,
    input  logic [1:0]             irq_en,
    input  logic                   start,
    input  logic                   stop,
    output logic                   mem_req,
    output logic [AW-1:0]          mem_addr,
    input  logic                   mem_ack,
    input  logic [PPDMA_DW-1:0]    mem_rdata,
    output logic                   per_valid,
    output logic [PPDMA_DW-1:0]    per_data,
    input  logic                   per_ready,
    output logic [1:0]             done,
    output logic                   active,
    output logic [CW-1:0]          residue,
    output logic                   busy,
    output logic                   irq
);
    logic [PPDMA_NSLOT-1:0][AW-1:0] slot_addr;
    logic [PPDMA_NSLOT-1:0][CW-1:0] slot_cnt;
    logic [PPDMA_NSLOT-1:0]         slot_en;
    logic [PPDMA_NSLOT-1:0]         slot_done;
    logic [PPDMA_NSLOT-1:0]         finish;

    for (genvar gi = 0; gi < PPDMA_NSLOT; gi++) begin : g_slot
        localparam logic SEL = 1'(gi);
        ppdma_slot #(.AW(AW), .CW(CW)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (desc_wr && (desc_sel == SEL)),
            .wr_addr  (desc_addr),
            .wr_cnt   (desc_cnt),
            .arm      (en_set[gi]),
            .clr_done (done_clr[gi]),
            .finish   (finish[gi]),
            .addr     (slot_addr[gi]),
            .cnt      (slot_cnt[gi]),
            .en       (slot_en[gi]),
            .done     (slot_done[gi])
        );
    end

    ppdma_engine #(.AW(AW), .CW(CW)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .stop      (stop),
        .slot_addr (slot_addr),
        .slot_cnt  (slot_cnt),
        .slot_en   (slot_en),
        .finish    (finish),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .per_valid (per_valid),
        .per_data  (per_data),
        .per_ready (per_ready),
        .active    (active),
        .residue   (residue),
        .busy      (busy)
    );

    assign done = slot_done;
    assign irq  = |(slot_done & irq_en);
endmodule

// File: rtl/ppdma_channel_chk.sv
module ppdma_channel_chk #(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 14
) (
    input logic          clk,
    input logic          rst_n,
    input logic [1:0]    done_clr,
    input logic          stop,
    input logic          mem_req,
    input logic [AW-1:0] mem_addr,
    input logic          mem_ack,
    input logic          per_valid,
    input logic [15:0]   per_data,
    input logic          per_ready,
    input logic [1:0]    done,
    input logic          active,
    input logic [CW-1:0] residue,
    input logic          busy
);
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

    p_push_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        per_valid && !per_ready |=> per_valid && $stable(per_data));

    p_one_phase_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && per_valid));

    p_flip_slot0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done[0]) |-> active);

    p_flip_slot1_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done[1]) |-> !active);

    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req && !per_valid);

    p_done0_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done[0] && !done_clr[0] |=> done[0]);

    p_done1_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done[1] && !done_clr[1] |=> done[1]);

    p_residue_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        per_valid && per_ready && residue > CW'(1) |=> residue == $past(residue) - CW'(1));

    p_stop_no_new_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop && !mem_req |=> !mem_req);
endmodule

bind ppdma_channel ppdma_channel_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .done_clr  (done_clr),
    .stop      (stop),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .per_valid (per_valid),
    .per_data  (per_data),
    .per_ready (per_ready),
    .done      (done),
    .active    (active),
    .residue   (residue),
    .busy      (busy)
);

// File: tb/tb_ppdma_channel.sv
module tb_ppdma_channel;
    localparam int AW = 32;
    localparam int CW = 14;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n;
    logic          desc_wr, desc_sel;
    logic [AW-1:0] desc_addr;
    logic [CW-1:0] desc_cnt;
    logic [1:0]    en_set, done_clr, irq_en;
    logic          start, stop;
    logic          mem_req, mem_ack;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_rdata;
    logic          per_valid, per_ready;
    logic [15:0]   per_data;
    logic [1:0]    done;
    logic          active, busy, irq;
    logic [CW-1:0] residue;

    logic stall_mode, ack_hold, tog;

    ppdma_channel #(.AW(AW), .CW(CW)) dut (
        .clk(clk), .rst_n(rst_n), .desc_wr(desc_wr), .desc_sel(desc_sel),
        .desc_addr(desc_addr), .desc_cnt(desc_cnt), .en_set(en_set),
        .done_clr(done_clr), .irq_en(irq_en), .start(start), .stop(stop),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .per_valid(per_valid), .per_data(per_data),
        .per_ready(per_ready), .done(done), .active(active),
        .residue(residue), .busy(busy), .irq(irq)
    );

    function automatic logic [15:0] fexp(input logic [31:0] a);
        return a[15:0] ^ 16'h5A3C;
    endfunction

    // memory and FIFO models
    always @(posedge clk) tog <= ~tog;
    assign mem_ack   = mem_req & (~stall_mode | tog) & ~ack_hold;
    assign mem_rdata = fexp(mem_addr);
    assign per_ready = ~stall_mode | ~tog;

    int          nlog = 0;
    logic [15:0] logw [256];
    always @(posedge clk)
        if (rst_n && per_valid && per_ready) begin
            logw[nlog[7:0]] <= per_data;
            nlog <= nlog + 1;
        end

    int n_chk = 0;
    int n_err = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr_desc(input logic sel, input logic [31:0] a, input int c);
        desc_wr = 1'b1; desc_sel = sel; desc_addr = a; desc_cnt = CW'(c);
        @(negedge clk);
        desc_wr = 1'b0;
    endtask

    task automatic pulse_en(input logic [1:0] m);
        en_set = m; @(negedge clk); en_set = 2'b00;
    endtask

    task automatic pulse_clr(input logic [1:0] m);
        done_clr = m; @(negedge clk); done_clr = 2'b00;
    endtask

    task automatic pulse_start();
        start = 1'b1; @(negedge clk); start = 1'b0;
    endtask

    task automatic pulse_stop();
        stop = 1'b1; @(negedge clk); stop = 1'b0;
    endtask

    task automatic wait_done(input logic [1:0] m);
        for (int t = 0; t < 3000 && ((done & m) != m); t++) @(negedge clk);
    endtask

    task automatic chk_words(input string req, input int base,
                             input logic [31:0] a, input int c);
        for (int k = 0; k < c; k++)
            chk(logw[(base + k) % 256] == fexp(a + 32'(2 * k)), req, "word",
                logw[(base + k) % 256], fexp(a + 32'(2 * k)));
    endtask

    localparam int NV = 4;
    localparam logic [31:0] VA0 [NV] = '{32'h1000, 32'h3002, 32'h4000, 32'h5010};
    localparam int          VC0 [NV] = '{4, 1, 6, 3};
    localparam logic [31:0] VA1 [NV] = '{32'h2000, 32'h3100, 32'h4000, 32'h6000};
    localparam int          VC1 [NV] = '{3, 5, 2, 1};
    localparam bit          VS  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1};

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        int base;
        tog = 1'b0;
        rst_n = 1'b0; desc_wr = 1'b0; desc_sel = 1'b0; desc_addr = '0;
        desc_cnt = '0; en_set = 2'b00; done_clr = 2'b00; irq_en = 2'b00;
        start = 1'b0; stop = 1'b0; stall_mode = 1'b0; ack_hold = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(!mem_req && !per_valid, "R1", "handshakes idle", {mem_req, per_valid}, 0);
        chk(!busy && !irq, "R1", "busy/irq", {busy, irq}, 0);
        chk(done == 2'b00, "R1", "done", done, 0);
        chk(!active && residue == '0, "R1", "active/residue", {active, residue}, 0);

        // vector table: R2 R3 R4 R5 ping-pong runs
        for (int v = 0; v < NV; v++) begin
            base = nlog;
            stall_mode = VS[v];
            wr_desc(1'b0, VA0[v], VC0[v]);
            wr_desc(1'b1, VA1[v], VC1[v]);
            pulse_en(2'b11);
            pulse_start();
            wait_done(2'b11);
            repeat (3) @(negedge clk);
            chk(nlog - base == VC0[v] + VC1[v], "R2", "word count", nlog - base, VC0[v] + VC1[v]);
            chk_words("R2", base, VA0[v], VC0[v]);
            chk_words("R5", base + VC0[v], VA1[v], VC1[v]);
            chk(done == 2'b11 && !active, "R4", "done/active", {done, active}, 3'b110);
            chk(residue == '0 && !busy, "R8", "residue/busy at end", {residue, busy}, 0);
            pulse_stop();
            pulse_clr(2'b11);
        end
        stall_mode = 1'b0;

        // R5 single armed slot: channel waits instead of reusing slot 1
        base = nlog;
        wr_desc(1'b0, 32'h7000, 3);
        pulse_en(2'b01);
        pulse_start();
        wait_done(2'b01);
        repeat (6) @(negedge clk);
        chk(nlog - base == 3, "R5", "words while other slot idle", nlog - base, 3);
        chk_words("R2", base, 32'h7000, 3);
        chk(active && !busy && !mem_req, "R5", "waiting on slot 1", {active, busy, mem_req}, 3'b100);
        chk(done == 2'b01, "R6", "done held", done, 2'b01);

        // R7 interrupt masking
        irq_en = 2'b00; #1;
        chk(!irq, "R7", "irq masked", irq, 0);
        irq_en = 2'b10; #1;
        chk(!irq, "R7", "irq other slot", irq, 0);
        irq_en = 2'b01; #1;
        chk(irq, "R7", "irq enabled", irq, 1);
        @(negedge clk);
        pulse_clr(2'b01);
        chk(!irq && done == 2'b00, "R6", "cleared by done_clr", {irq, done}, 0);
        irq_en = 2'b00;

        // R5 late refill of slot 1 resumes the running channel
        base = nlog;
        wr_desc(1'b1, 32'h7100, 2);
        pulse_en(2'b10);
        wait_done(2'b10);
        repeat (3) @(negedge clk);
        chk(nlog - base == 2, "R5", "resume after late arm", nlog - base, 2);
        chk_words("R5", base, 32'h7100, 2);
        chk(!active && done == 2'b10, "R4", "flip back to slot 0", {active, done}, 3'b010);
        pulse_clr(2'b11);

        // R10 zero-length slot
        base = nlog;
        wr_desc(1'b0, 32'h7200, 0);
        pulse_en(2'b01);
        repeat (3) @(negedge clk);
        chk(done == 2'b01 && active, "R10", "zero count completes", {done, active}, 3'b011);
        chk(nlog == base && !busy, "R10", "no transfer", nlog - base, 0);
        pulse_clr(2'b11);
        pulse_stop();

        // R9 R11 R3 R8 stop during a held read, rewrite, restart
        base = nlog;
        ack_hold = 1'b1;
        wr_desc(1'b1, 32'h8000, 8);
        pulse_en(2'b10);
        pulse_start();
        for (int t = 0; t < 20 && !mem_req; t++) @(negedge clk);
        chk(mem_req && mem_addr == 32'h8000, "R2", "first read address", mem_addr, 32'h8000);
        chk(residue == CW'(8), "R8", "residue loaded", residue, 8);
        pulse_stop();
        wr_desc(1'b1, 32'h9000, 5);
        repeat (2) @(negedge clk);
        chk(mem_req && mem_addr == 32'h8000, "R11", "in-flight read kept", mem_addr, 32'h8000);
        ack_hold = 1'b0;
        repeat (5) @(negedge clk);
        chk(nlog - base == 1, "R9", "outstanding word completes", nlog - base, 1);
        chk(logw[base % 256] == fexp(32'h8000), "R9", "outstanding word", logw[base % 256], fexp(32'h8000));
        chk(!busy && !mem_req, "R9", "no new request after stop", {busy, mem_req}, 0);
        chk(residue == CW'(7), "R8", "residue after one word", residue, 7);
        base = nlog;
        pulse_start();
        wait_done(2'b10);
        repeat (3) @(negedge clk);
        chk(nlog - base == 5, "R11", "restart uses new count", nlog - base, 5);
        chk_words("R9", base, 32'h9000, 5);

        summary();
        $finish;
    end
endmodule